// File: doc/BRIEF.md
# Trap-Control Register Access Gate

This block holds a 64-bit control word whose set bits ask for reads of activity-counter registers to be trapped. It also decides what happens to each system-register read or write that names that word. A decoded request arrives with its five encoding fields, the requesting privilege level, the three nested-virtualization control bits and the secure-monitor state. The gate picks one of four outcomes:

- perform the access on the stored word;
- redirect the access to a fixed memory offset;
- trap it to a higher level, with an exception class code;
- declare it undefined.

The memory access and the exception entry are carried out elsewhere. The gate returns a result code, a target level, a class code, an offset and read data one cycle after it accepts the request. Whether the feature set, a hypervisor level and a monitor level are present is given on static configuration inputs.

Privilege levels are encoded on `req_level` as 0 user, 1 kernel, 2 hypervisor and 3 monitor. Result codes on `rsp_kind` are 0 access, 1 redirect, 2 trap and 3 undefined. The implemented bits of the word are 49:17 and 4:0.

Top module: `trap_gate`

## Requirements
- R1: Only the encoding op0=2'b11, op1=3'b100, CRn=4'b0011, CRm=4'b0001, op2=3'b110 selects the word. Any other encoding gives result 3 (undefined) and leaves the word unchanged.
- R2: With `cfg_feat_ok` low, every request gives result 3 (undefined).
- R3: A request from level 0 (user) gives result 3 (undefined).
- R4: At level 1 (kernel) with a hypervisor present, the nested bits `nv[2:0]` decide the outcome:
  - if nv[2] and nv[0] are both 1, the result is 1 (redirect) with offset 0x1E8;
  - otherwise, if nv[0] is 1, the result is 2 (trap) with target level 2 and class 0x18;
  - otherwise, the result is 3 (undefined).
- R5: At level 2 (hypervisor) with a monitor present and `mon_fg_en` low, the outcome depends on the two debug-undefined flags:
  - if `sdd_undef_prio` is set, the result is 3 (undefined);
  - otherwise, if `sdd_undef` is set, the result is 3 (undefined);
  - otherwise, the result is 2 (trap) with target level 3 and class 0x18.
- R6: The result is 0 (access) in two cases: at level 2 when the R5 condition does not hold, and always at level 3. A write then stores the data, and a read returns the stored word.
- R7: With `cfg_has_hyp` low:
  - requests from levels 1 and 2 are undefined;
  - a level-3 read returns zero;
  - a level-3 write leaves the stored word unchanged.
- R8: Bits 63:50 and 16:5 always read as zero, whatever data is written.
- R9: While reset is asserted, `req_ready` and `rsp_done` are low. After reset the word reads as zero.
- R10: `rsp_done` pulses for exactly one cycle, in the cycle after each accepted request. Fields that do not apply to the result read as zero: the target and class unless the result is a trap, the offset unless it is a redirect, and the read data unless it is an access read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_feat_ok | input | 1 | Required feature set present |
| cfg_has_hyp | input | 1 | Hypervisor level implemented |
| cfg_has_mon | input | 1 | Monitor level implemented |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Gate can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_level | input | 2 | Requesting privilege level |
| req_wdata | input | 64 | Write data |
| nv_bits | input | 3 | Nested-virtualization control bits |
| mon_fg_en | input | 1 | Monitor fine-grained trap enable |
| sdd_undef_prio | input | 1 | Debug-undefined condition, priority form |
| sdd_undef | input | 1 | Debug-undefined condition, plain form |
| rsp_done | output | 1 | Result valid pulse |
| rsp_kind | output | 2 | Result code |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap class code |
| rsp_offset | output | 12 | Redirect memory offset |
| rsp_rdata | output | 64 | Read data |

## Verification
All results are registered once: a request accepted at a rising edge produces `rsp_done` and every result field in the cycle after that edge. A write takes effect at that same edge, so a read issued in the next cycle already sees the new value. The bench drives each request on a falling edge and samples all result fields on the next falling edge, one rising edge later. It checks that `rsp_done` has dropped again after an idle cycle. Expected outcomes come from a bench model of the level and flag priorities and a shadow copy of the stored word.

// File: rtl/trap_gate_pkg.sv
package trap_gate_pkg;
  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  typedef enum logic [1:0] {
    RES_ACCESS   = 2'd0,
    RES_REDIRECT = 2'd1,
    RES_TRAP     = 2'd2,
    RES_UNDEF    = 2'd3
  } result_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysenc_t;
endpackage

// File: rtl/trap_gate_policy.sv
module trap_gate_policy
  import trap_gate_pkg::*;
#(
  parameter logic [15:0] SEL_ENC = 16'b11_100_0011_0001_110
) (
  input  sysenc_t    enc,
  input  level_e     level,
  input  logic [2:0] nv,
  input  logic       feat_ok,
  input  logic       has_hyp,
  input  logic       has_mon,
  input  logic       fg_en,
  input  logic       sdd_prio,
  input  logic       sdd_plain,
  output result_e    kind,
  output level_e     target
);
  logic hit;
  assign hit = (enc == sysenc_t'(SEL_ENC));

  always_comb begin
    kind   = RES_UNDEF;
    target = LVL_USER;
    if (feat_ok && hit) begin
      case (level)
        LVL_KERNEL: begin
          if (has_hyp) begin
            if (nv[2] && nv[0]) begin
              kind = RES_REDIRECT;
            end else if (nv[0]) begin
              kind   = RES_TRAP;
              target = LVL_HYP;
            end
          end
        end
        LVL_HYP: begin
          if (has_hyp) begin
            if (has_mon && !fg_en) begin
              if (!sdd_prio && !sdd_plain) begin
                kind   = RES_TRAP;
                target = LVL_MON;
              end
            end else begin
              kind = RES_ACCESS;
            end
          end
        end
        LVL_MON: kind = RES_ACCESS;
        default: kind = RES_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/trap_gate_store.sv
module trap_gate_store #(
  parameter int DATA_W = 64,
  parameter int LO_MSB = 4,
  parameter int HI_LSB = 17,
  parameter int HI_MSB = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_keep
    assign keep[b] = (b <= LO_MSB) || ((b >= HI_LSB) && (b <= HI_MSB));
  end

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wdata & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign q = word_q;
endmodule

// File: rtl/trap_gate.sv
module trap_gate
  import trap_gate_pkg::*;
#(
  parameter int          DATA_W      = 64,
  parameter int          LO_MSB      = 4,
  parameter int          HI_LSB      = 17,
  parameter int          HI_MSB      = 49,
  parameter int          OFS_W       = 12,
  parameter int          CLASS_W     = 6,
  parameter logic [11:0] REDIR_OFS   = 12'h1E8,
  parameter logic [5:0]  TRAP_CLASS  = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_feat_ok,
  input  logic               cfg_has_hyp,
  input  logic               cfg_has_mon,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic [1:0]         req_level,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [2:0]         nv_bits,
  input  logic               mon_fg_en,
  input  logic               sdd_undef_prio,
  input  logic               sdd_undef,
  output logic               rsp_done,
  output logic [1:0]         rsp_kind,
  output logic [1:0]         rsp_target,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [OFS_W-1:0]   rsp_offset,
  output logic [DATA_W-1:0]  rsp_rdata
);
  localparam logic [OFS_W-1:0]   OFS_V   = OFS_W'(REDIR_OFS);
  localparam logic [CLASS_W-1:0] CLASS_V = CLASS_W'(TRAP_CLASS);

  result_e           pol_kind;
  level_e            pol_target;
  sysenc_t           enc;
  logic              accept;
  logic              wr_en;
  logic [DATA_W-1:0] word;

  logic               ready_q, done_q, done_d;
  logic [1:0]         kind_q, kind_d, tgt_q, tgt_d;
  logic [CLASS_W-1:0] cls_q, cls_d;
  logic [OFS_W-1:0]   ofs_q, ofs_d;
  logic [DATA_W-1:0]  rd_q, rd_d;

  assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};

  trap_gate_policy u_policy (
    .enc       (enc),
    .level     (level_e'(req_level)),
    .nv        (nv_bits),
    .feat_ok   (cfg_feat_ok),
    .has_hyp   (cfg_has_hyp),
    .has_mon   (cfg_has_mon),
    .fg_en     (mon_fg_en),
    .sdd_prio  (sdd_undef_prio),
    .sdd_plain (sdd_undef),
    .kind      (pol_kind),
    .target    (pol_target)
  );

  assign accept = req_valid && ready_q;
  assign wr_en  = accept && req_write && (pol_kind == RES_ACCESS) && cfg_has_hyp;

  trap_gate_store #(
    .DATA_W (DATA_W),
    .LO_MSB (LO_MSB),
    .HI_LSB (HI_LSB),
    .HI_MSB (HI_MSB)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (req_wdata),
    .q     (word)
  );

  always_comb begin
    done_d = accept;
    kind_d = pol_kind;
    tgt_d  = (pol_kind == RES_TRAP) ? pol_target : LVL_USER;
    cls_d  = (pol_kind == RES_TRAP) ? CLASS_V : '0;
    ofs_d  = (pol_kind == RES_REDIRECT) ? OFS_V : '0;
    rd_d   = ((pol_kind == RES_ACCESS) && !req_write && cfg_has_hyp) ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      tgt_q  <= '0;
      cls_q  <= '0;
      ofs_q  <= '0;
      rd_q   <= '0;
    end else if (accept) begin
      kind_q <= kind_d;
      tgt_q  <= tgt_d;
      cls_q  <= cls_d;
      ofs_q  <= ofs_d;
      rd_q   <= rd_d;
    end
  end

  assign req_ready  = ready_q;
  assign rsp_done   = done_q;
  assign rsp_kind   = kind_q;
  assign rsp_target = tgt_q;
  assign rsp_class  = cls_q;
  assign rsp_offset = ofs_q;
  assign rsp_rdata  = rd_q;
endmodule

// File: rtl/trap_gate_chk.sv
module trap_gate_chk #(
  parameter int          DATA_W     = 64,
  parameter int          LO_MSB     = 4,
  parameter int          HI_LSB     = 17,
  parameter int          HI_MSB     = 49,
  parameter int          OFS_W      = 12,
  parameter int          CLASS_W    = 6,
  parameter logic [11:0] REDIR_OFS  = 12'h1E8,
  parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_feat_ok,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_level,
  input logic               rsp_done,
  input logic [1:0]         rsp_kind,
  input logic [1:0]         rsp_target,
  input logic [CLASS_W-1:0] rsp_class,
  input logic [OFS_W-1:0]   rsp_offset,
  input logic [DATA_W-1:0]  rsp_rdata
);
  function automatic logic [DATA_W-1:0] rsvd_mask();
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++)
      m[b] = !((b <= LO_MSB) || ((b >= HI_LSB) && (b <= HI_MSB)));
    return m;
  endfunction
  localparam logic [DATA_W-1:0] RSVD = rsvd_mask();

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_done); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_done); // R10
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_level == 2'd0) |=> (rsp_kind == 2'd3)); // R3
  AST_NOFEAT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_feat_ok) |=> (rsp_kind == 2'd3)); // R2
  AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_kind == 2'd2) |-> (rsp_target[1] && rsp_class == CLASS_W'(TRAP_CLASS))); // R4
  AST_REDIRECT_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_kind == 2'd1) |-> (rsp_offset == OFS_W'(REDIR_OFS))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ((rsp_rdata & RSVD) == '0)); // R8
  AST_NONACCESS_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_kind != 2'd0) |-> (rsp_rdata == '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!req_ready && !rsp_done)); // R9
endmodule

bind trap_gate trap_gate_chk #(
  .DATA_W(DATA_W), .LO_MSB(LO_MSB), .HI_LSB(HI_LSB), .HI_MSB(HI_MSB),
  .OFS_W(OFS_W), .CLASS_W(CLASS_W), .REDIR_OFS(REDIR_OFS), .TRAP_CLASS(TRAP_CLASS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_feat_ok(cfg_feat_ok), .req_valid(req_valid),
  .req_ready(req_ready), .req_level(req_level), .rsp_done(rsp_done),
  .rsp_kind(rsp_kind), .rsp_target(rsp_target), .rsp_class(rsp_class),
  .rsp_offset(rsp_offset), .rsp_rdata(rsp_rdata)
);

// File: tb/trap_gate_tb.sv
`timescale 1ns/1ps
module trap_gate_tb;
  localparam real HALF = 2.0;
  localparam logic [63:0] KEEP = {14'b0, 33'h1_FFFF_FFFF, 12'b0, 5'h1F};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_feat_ok, cfg_has_hyp, cfg_has_mon;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_op0;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn, req_crm;
  logic [2:0]  req_op2;
  logic [1:0]  req_level;
  logic [63:0] req_wdata;
  logic [2:0]  nv_bits;
  logic        mon_fg_en, sdd_undef_prio, sdd_undef;
  logic        rsp_done;
  logic [1:0]  rsp_kind, rsp_target;
  logic [5:0]  rsp_class;
  logic [11:0] rsp_offset;
  logic [63:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] shadow;

  always #(HALF) clk = ~clk;

  trap_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_feat_ok(cfg_feat_ok), .cfg_has_hyp(cfg_has_hyp),
    .cfg_has_mon(cfg_has_mon), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
    .req_crm(req_crm), .req_op2(req_op2), .req_level(req_level), .req_wdata(req_wdata),
    .nv_bits(nv_bits), .mon_fg_en(mon_fg_en), .sdd_undef_prio(sdd_undef_prio),
    .sdd_undef(sdd_undef), .rsp_done(rsp_done), .rsp_kind(rsp_kind),
    .rsp_target(rsp_target), .rsp_class(rsp_class), .rsp_offset(rsp_offset),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected outcome: kind, target and a requirement tag
  function automatic void predict(input bit hit, input logic [1:0] lvl,
                                  output logic [1:0] kind, output logic [1:0] tgt,
                                  output string tag);
    kind = 2'd3; tgt = 2'd0; tag = "R1";
    if (!cfg_feat_ok) begin tag = "R2"; return; end
    if (!hit) begin tag = "R1"; return; end
    case (lvl)
      2'd0: tag = "R3";
      2'd1: begin
        if (!cfg_has_hyp) tag = "R7";
        else begin
          tag = "R4";
          if (nv_bits[0] && nv_bits[2]) kind = 2'd1;
          else if (nv_bits[0]) begin kind = 2'd2; tgt = 2'd2; end
        end
      end
      2'd2: begin
        if (!cfg_has_hyp) tag = "R7";
        else if (cfg_has_mon && !mon_fg_en) begin
          tag = "R5";
          if (!sdd_undef_prio && !sdd_undef) begin kind = 2'd2; tgt = 2'd3; end
        end else begin tag = "R6"; kind = 2'd0; end
      end
      default: begin kind = 2'd0; tag = cfg_has_hyp ? "R6" : "R7"; end
    endcase
  endfunction

  task automatic do_req(bit wr, logic [1:0] lvl, logic [63:0] wd, bit hit);
    logic [1:0] ek, et;
    logic [63:0] erd;
    string tag;
    predict(hit, lvl, ek, et, tag);
    erd = (ek == 2'd0 && !wr && cfg_has_hyp) ? shadow : 64'd0;
    req_valid = 1'b1; req_write = wr; req_level = lvl; req_wdata = wd;
    req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b0011; req_crm = 4'b0001;
    req_op2 = hit ? 3'b110 : (3'b110 ^ 3'(1 + $urandom % 7));
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "done", 64'(rsp_done), 64'd1);
    check(tag, "kind", 64'(rsp_kind), 64'(ek));
    check(tag, "target", 64'(rsp_target), 64'(et));
    check(tag, "class", 64'(rsp_class), (ek == 2'd2) ? 64'h18 : 64'd0);
    check(tag, "offset", 64'(rsp_offset), (ek == 2'd1) ? 64'h1E8 : 64'd0);
    check(tag, "rdata", rsp_rdata, erd);
    if (ek == 2'd0 && wr && cfg_has_hyp) shadow = wd & KEEP;
  endtask

  task automatic set_ctx(bit f, bit h, bit m, logic [2:0] nv, bit fg, bit sp, bit sd);
    cfg_feat_ok = f; cfg_has_hyp = h; cfg_has_mon = m; nv_bits = nv;
    mon_fg_en = fg; sdd_undef_prio = sp; sdd_undef = sd;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    shadow = 64'd0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_level = 2'd0;
    req_wdata = '0; req_op0 = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0;
    set_ctx(1, 1, 1, 3'b000, 1, 0, 0);
    repeat (3) @(negedge clk);
    check("R9", "ready in reset", 64'(req_ready), 64'd0);
    check("R9", "done in reset", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "ready after reset", 64'(req_ready), 64'd1);
    do_req(0, 2'd3, '0, 1);                       // R9 reset value reads 0
    @(negedge clk);
    check("R10", "done drops", 64'(rsp_done), 64'd0);

    do_req(1, 2'd3, '1, 1);                       // R8 reserved bits cleared
    do_req(0, 2'd3, '0, 1);
    check("R8", "all-ones write", rsp_rdata, KEEP);
    do_req(1, 2'd3, 64'hA5A5_5A5A_0F0F_F0F0, 0);  // R1 miss: no change
    do_req(0, 2'd3, '0, 1);
    do_req(0, 2'd0, '0, 1);                       // R3
    set_ctx(1, 1, 1, 3'b101, 1, 0, 0); do_req(0, 2'd1, '0, 1);   // R4 redirect
    set_ctx(1, 1, 1, 3'b111, 1, 0, 0); do_req(1, 2'd1, '0, 1);
    set_ctx(1, 1, 1, 3'b001, 1, 0, 0); do_req(0, 2'd1, '0, 1);   // R4 trap
    set_ctx(1, 1, 1, 3'b100, 1, 0, 0); do_req(0, 2'd1, '0, 1);   // R4 undef
    set_ctx(1, 1, 1, 3'b000, 0, 1, 0); do_req(0, 2'd2, '0, 1);   // R5 prio
    set_ctx(1, 1, 1, 3'b000, 0, 0, 1); do_req(0, 2'd2, '0, 1);   // R5 plain
    set_ctx(1, 1, 1, 3'b000, 0, 0, 0); do_req(1, 2'd2, '1, 1);   // R5 trap
    set_ctx(1, 1, 0, 3'b000, 0, 0, 0); do_req(1, 2'd2, 64'h0003_0000_0001_0013, 1); // R6
    do_req(0, 2'd2, '0, 1);
    set_ctx(1, 0, 1, 3'b101, 1, 0, 0);                           // R7
    do_req(1, 2'd3, '1, 1); do_req(0, 2'd3, '0, 1); do_req(0, 2'd1, '0, 1);
    set_ctx(1, 1, 1, 3'b101, 1, 0, 0); do_req(0, 2'd3, '0, 1);
    set_ctx(0, 1, 1, 3'b000, 1, 0, 0); do_req(1, 2'd3, '1, 1);   // R2

    for (int i = 0; i < 4000; i++) begin
      set_ctx(($urandom % 8) != 0, ($urandom % 6) != 0, $urandom % 2, 3'($urandom),
              $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0);
      do_req($urandom % 2, 2'($urandom), {$urandom, $urandom}, ($urandom % 8) != 0);
      if ((i % 16) == 0) begin
        @(negedge clk);
        check("R10", "idle done", 64'(rsp_done), 64'd0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule